// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a 32-bit processor core that completes one instruction on every rising clock edge. In one cycle it fetches a word from its instruction store, splits it into fields and reads two registers. It then runs the ALU, optionally reads or writes its data store, and writes a result register and the next program counter. It supports five register-to-register operations (add, subtract, AND, OR, signed set-less-than), word load, word store, branch-if-equal and an unconditional jump.

One opcode decoder produces a fixed set of control lines. These lines steer three multiplexers: the ALU second operand (register or sign-extended offset), the destination register field (rd or rt) and the write-back source (ALU result or loaded word). A branch/jump pair of selectors picks the next program counter. The instruction and data stores are internal word arrays that the surrounding environment fills before reset is released. A debug port shows the program counter and any register chosen by number.

Top module: `mini_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and all 32 registers become 0.
- R2: Opcode 0x00 (bits 31:26) with function 0x20 (bits 5:0) writes rs+rt, and function 0x22 writes rs-rt, into the register named by bits 15:11 (rs = bits 25:21, rt = bits 20:16).
- R3: Opcode 0x00 with function 0x24 writes rs AND rt, 0x25 writes rs OR rt, and 0x2A writes 1 if rs is less than rt as signed values, else 0, into the register in bits 15:11.
- R4: Opcode 0x23 loads the data word at byte address rs + sign-extended bits 15:0 (word index = address bits 7:2 at default size) into the register in bits 20:16.
- R5: Opcode 0x2B stores register rt to the data word at rs + sign-extended bits 15:0 and writes no register.
- R6: Opcode 0x04 sets the PC to PC+4+(sign-extended bits 15:0 shifted left 2) when rs equals rt, else to PC+4, and writes no register or memory.
- R7: Opcode 0x02 sets the PC to {bits 31:28 of PC+4, bits 25:0 of the instruction, 2'b00}.
- R8: Register 0 always reads 0; any write aimed at it is discarded.
- R9: Every instruction other than a taken branch or a jump advances the PC by 4.
- R10: `dbg_pc` shows the current PC, and `dbg_data` shows the register selected by `dbg_sel` in the same cycle.
- R11: An instruction with any other opcode changes no register and no memory word; it only advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dbg_sel | input | 5 | Register number to observe |
| dbg_pc | output | 32 | Current program counter |
| dbg_data | output | 32 | Contents of the selected register |

## Verification
The embedded assertions check every cycle that register 0 stays zero, that the PC stays word aligned and that a store never writes a register. They also check the next-PC rules for sequential flow, untaken branches and jumps. Arithmetic results, load and store addresses, sign extension of negative offsets, signed comparison and the effect of an unknown opcode can only be shown by the bench's program. That program runs in step with a behavioural model, and the full register file and PC are compared after every edge.

// File: rtl/mini_core.sv
`timescale 1ns/1ps
module mini_core #(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [4:0]  dbg_sel,
  output logic [31:0] dbg_pc,
  output logic [31:0] dbg_data
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_JUMP  = 6'h02;

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] regs [32];
  logic [31:0] pc;

  logic [31:0] instr;
  logic [5:0]  opcode, funct;
  logic [4:0]  rs, rt, rd;
  assign instr  = imem[pc[IAW+1:2]];
  assign opcode = instr[31:26];
  assign rs     = instr[25:21];
  assign rt     = instr[20:16];
  assign rd     = instr[15:11];
  assign funct  = instr[5:0];

  logic sel_dst_rd, sel_wb_mem, sel_b_imm, is_branch, is_jump;
  logic reg_we, mem_we, mem_re;

  always_comb begin
    sel_dst_rd = 1'b0;
    sel_wb_mem = 1'b0;
    sel_b_imm  = 1'b0;
    is_branch  = 1'b0;
    is_jump    = 1'b0;
    reg_we     = 1'b0;
    mem_we     = 1'b0;
    mem_re     = 1'b0;
    case (opcode)
      OP_RTYPE: begin sel_dst_rd = 1'b1; reg_we = 1'b1; end
      OP_LOAD:  begin sel_wb_mem = 1'b1; sel_b_imm = 1'b1; reg_we = 1'b1; mem_re = 1'b1; end
      OP_STORE: begin sel_b_imm = 1'b1; mem_we = 1'b1; end
      OP_BEQ:   is_branch = 1'b1;
      OP_JUMP:  is_jump = 1'b1;
      default: ;
    endcase
  end

  logic [31:0] rd1, rd2, imm_ext, alu_b, alu_res;
  logic        alu_zero;
  assign rd1     = regs[rs];
  assign rd2     = regs[rt];
  assign imm_ext = {{16{instr[15]}}, instr[15:0]};
  assign alu_b   = sel_b_imm ? imm_ext : rd2;

  always_comb begin
    if (opcode == OP_RTYPE) begin
      case (funct)
        6'h20:   alu_res = rd1 + alu_b;
        6'h22:   alu_res = rd1 - alu_b;
        6'h24:   alu_res = rd1 & alu_b;
        6'h25:   alu_res = rd1 | alu_b;
        6'h2A:   alu_res = {31'd0, $signed(rd1) < $signed(alu_b)};
        default: alu_res = '0;
      endcase
    end else if (is_branch) begin
      alu_res = rd1 - alu_b;
    end else begin
      alu_res = rd1 + alu_b;
    end
  end
  assign alu_zero = (alu_res == 32'd0);

  logic [DAW-1:0] dmem_idx;
  logic [31:0]    mem_rdata, wb_data;
  logic [4:0]     wb_reg;
  assign dmem_idx  = alu_res[DAW+1:2];
  assign mem_rdata = mem_re ? dmem[dmem_idx] : 32'd0;
  assign wb_reg    = sel_dst_rd ? rd : rt;
  assign wb_data   = sel_wb_mem ? mem_rdata : alu_res;

  logic [31:0] pc_plus4, br_target, jmp_target, pc_after_br, pc_next;
  assign pc_plus4    = pc + 32'd4;
  assign br_target   = pc_plus4 + {imm_ext[29:0], 2'b00};
  assign jmp_target  = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign pc_after_br = (is_branch && alu_zero) ? br_target : pc_plus4;
  assign pc_next     = is_jump ? jmp_target : pc_after_br;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      for (int i = 0; i < 32; i++) regs[i] <= '0;
    end else begin
      pc <= pc_next;
      if (reg_we && wb_reg != 5'd0) regs[wb_reg] <= wb_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && mem_we) dmem[dmem_idx] <= rd2;
  end

  assign dbg_pc   = pc;
  assign dbg_data = regs[dbg_sel];

  AST_R0_ZERO: assert property (@(posedge clk) disable iff (rst) regs[0] == 32'd0); // R8
  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst) pc[1:0] == 2'b00); // R6
  AST_STORE_NO_REGWR: assert property (@(posedge clk) disable iff (rst) mem_we |-> !reg_we); // R5
  AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst) (!is_branch && !is_jump) |=> pc == $past(pc) + 32'd4); // R9
  AST_BEQ_FALLTHRU: assert property (@(posedge clk) disable iff (rst) (is_branch && rd1 != rd2) |=> pc == $past(pc) + 32'd4); // R6
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst) is_jump |=> pc[27:2] == $past(instr[25:0])); // R7
endmodule

// File: tb/test_mini_core.sv
`timescale 1ns/1ps
module test_mini_core;
  localparam real CLK_PERIOD = 10.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  dbg_sel = '0;
  logic [31:0] dbg_pc, dbg_data;

  mini_core i_mini_core (.clk(clk), .rst(rst), .dbg_sel(dbg_sel), .dbg_pc(dbg_pc), .dbg_data(dbg_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] bprog [64];
  logic [31:0] mreg [32];
  logic [31:0] mmem [64];
  logic [31:0] mpc;
  string tag;

  function automatic logic [31:0] r_ins(int s, int t, int d, logic [5:0] fn);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, fn};
  endfunction
  function automatic logic [31:0] i_ins(logic [5:0] op, int s, int t, int imm);
    return {op, 5'(s), 5'(t), 16'(imm)};
  endfunction
  function automatic logic [31:0] j_ins(int idx);
    return {6'h02, 26'(idx)};
  endfunction

  task automatic model_step();
    logic [31:0] ins, a, b, res, sx, ea, npc;
    ins = bprog[mpc[7:2]];
    a = mreg[ins[25:21]];
    b = mreg[ins[20:16]];
    sx = {{16{ins[15]}}, ins[15:0]};
    ea = a + sx;
    npc = mpc + 32'd4;
    case (ins[31:26])
      6'h00: begin
        case (ins[5:0])
          6'h20: res = a + b;
          6'h22: res = a - b;
          6'h24: res = a & b;
          6'h25: res = a | b;
          6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: res = 32'd0;
        endcase
        if (ins[15:11] != 0) mreg[ins[15:11]] = res;
        if (ins[15:11] == 0) tag = "R8";
        else if (ins[5:0] == 6'h20 || ins[5:0] == 6'h22) tag = "R2";
        else tag = "R3";
      end
      6'h23: begin if (ins[20:16] != 0) mreg[ins[20:16]] = mmem[ea[7:2]]; tag = "R4"; end
      6'h2B: begin mmem[ea[7:2]] = b; tag = "R5"; end
      6'h04: begin if (a == b) npc = mpc + 32'd4 + (sx << 2); tag = "R6"; end
      6'h02: begin npc = {npc[31:28], ins[25:0], 2'b00}; tag = "R7"; end
      default: tag = "R11";
    endcase
    mpc = npc;
  endtask

  task automatic compare_all();
    compared++;
    if (dbg_pc !== mpc) begin // R9 R10
      mismatched++;
      $display("FAIL %s pc: actual %h expected %h", tag, dbg_pc, mpc);
    end
    for (int r = 0; r < 32; r++) begin
      dbg_sel = 5'(r);
      #0.1;
      compared++;
      if (dbg_data !== mreg[r]) begin // R10 debug read
        mismatched++;
        $display("FAIL %s reg%0d: actual %h expected %h", tag, r, dbg_data, mreg[r]);
      end
    end
  endtask

  initial begin
    for (int k = 0; k < 64; k++) begin bprog[k] = '0; mmem[k] = '0; end
    for (int k = 0; k < 32; k++) mreg[k] = '0;
    mmem[0] = 32'd5;
    mmem[1] = 32'hFFFF_FFFD;
    bprog[0]  = i_ins(6'h23, 0, 1, 0);     // R4
    bprog[1]  = i_ins(6'h23, 0, 2, 4);     // R4
    bprog[2]  = r_ins(1, 2, 3, 6'h20);     // R2
    bprog[3]  = r_ins(1, 2, 4, 6'h22);     // R2
    bprog[4]  = r_ins(1, 2, 5, 6'h24);     // R3
    bprog[5]  = r_ins(1, 2, 6, 6'h25);     // R3
    bprog[6]  = r_ins(2, 1, 7, 6'h2A);     // R3 signed true
    bprog[7]  = r_ins(1, 2, 8, 6'h2A);     // R3 signed false
    bprog[8]  = i_ins(6'h2B, 0, 4, 8);     // R5
    bprog[9]  = i_ins(6'h23, 0, 9, 8);     // R4
    bprog[10] = i_ins(6'h2B, 4, 3, -4);    // R5 negative offset
    bprog[11] = i_ins(6'h23, 0, 13, 4);    // R4
    bprog[12] = r_ins(1, 1, 0, 6'h20);     // R8
    bprog[13] = i_ins(6'h04, 1, 2, 5);     // R6 not taken
    bprog[14] = i_ins(6'h04, 3, 13, 1);    // R6 taken
    bprog[15] = r_ins(1, 1, 14, 6'h20);
    bprog[16] = 32'hFC00_0000;             // R11
    bprog[17] = j_ins(20);                 // R7
    bprog[18] = r_ins(1, 1, 15, 6'h20);
    bprog[19] = r_ins(1, 1, 15, 6'h20);
    bprog[20] = r_ins(2, 1, 16, 6'h22);
    bprog[21] = i_ins(6'h04, 0, 0, -1);    // R6 backward self loop
    for (int k = 0; k < 64; k++) begin
      i_mini_core.imem[k] = bprog[k];
      i_mini_core.dmem[k] = mmem[k];
    end
    mpc = '0;
    tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all();                         // R1 reset state
    rst = 1'b0;
    for (int c = 0; c < 40; c++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule